// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches page mappings for a processor's memory pipeline. Each of its entries maps a virtual page number, together with an 8-bit address-space identifier, to a physical page number. Each entry also holds access permissions and valid, referenced and modified flags. A lookup compares every entry in parallel. One cycle later it answers with a hit and the physical address, a permission fault, or a miss. A page walker outside the block installs new mappings through the fill port.

A displaced valid entry leaves the block as a write-back record on its own port. The record carries the entry's identifier, its page number and its referenced and modified flags, so the page table can be brought up to date. A fill picks the entry it replaces in this order: an existing entry with the same tag, then the lowest-numbered free entry, then a pseudo-random one. A flush walks the table one entry per cycle and invalidates every entry of one address space, or every entry. Each entry it evicts produces a write-back record.

Top module: `tlb_fa`

## Requirements
- R1: After reset no entry is valid, `rsp_valid`, `wb_valid` and `flush_busy` are 0, and any lookup misses.
- R2: A lookup accepted at one clock edge is answered at the next: `rsp_valid` is 1 for one cycle. `rsp_hit` is 1 when a valid entry has the same identifier and the same page number `lk_vaddr[31:12]` and permits the access. On a hit `rsp_paddr` is the stored physical page number over `lk_vaddr[11:0]`.
- R3: The permission bits are bit 0 read, bit 1 write and bit 2 fetch. The access codes are 0 read, 1 write, 2 fetch, and code 3 is never permitted. A matching entry that forbids the access answers `rsp_fault`=1 with `rsp_hit`=0, and its flags stay unchanged.
- R4: A hit sets the entry's referenced flag, and a write hit also sets its modified flag. These flags appear in the entry's later write-back record.
- R5: An entry whose page number matches but whose address-space identifier differs gives a miss.
- R6: A fill whose identifier and page number match a valid entry overwrites that entry. A write-back record with the old flags appears in the cycle after the fill.
- R7: A fill that matches no entry takes a free entry while one exists, and then emits no write-back record.
- R8: A fill into a full table with no matching entry evicts one valid entry. In the next cycle it emits that entry's identifier, page number, referenced flag and modified flag, and the evicted mapping is gone.
- R9: A flush of one identifier holds `flush_busy` for exactly ENTRIES cycles. It emits one record for each evicted entry of that identifier and leaves entries of other identifiers intact.
- R10: A flush with `flush_all`=1 evicts every valid entry, with one record each.
- R11: A lookup presented while `flush_busy` is 1, or in the same cycle as a fill or a flush request, gets no response. Priority is flush request, then fill, then lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Address-space identifier of the lookup |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| fill_valid | input | 1 | Install a mapping |
| fill_asid | input | 8 | Identifier of the new mapping |
| fill_vpn | input | 20 | Virtual page number of the new mapping |
| fill_ppn | input | 20 | Physical page number of the new mapping |
| fill_perm | input | 3 | Permissions {fetch, write, read} |
| flush_valid | input | 1 | Start a flush |
| flush_all | input | 1 | Flush every identifier |
| flush_asid | input | 8 | Identifier to flush when `flush_all` is 0 |
| flush_busy | output | 1 | Flush scan in progress |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Mapping present but access forbidden |
| rsp_paddr | output | 32 | Physical address on a hit |
| wb_valid | output | 1 | Write-back record present |
| wb_asid | output | 8 | Identifier of the evicted entry |
| wb_vpn | output | 20 | Page number of the evicted entry |
| wb_ref | output | 1 | Referenced flag of the evicted entry |
| wb_dirty | output | 1 | Modified flag of the evicted entry |

## Verification
The bench fills the table until it is full and then forces a random eviction. It checks that the record names an entry that really was resident and carries that entry's flags. A wrong victim mask or stale flags would show up there as an unknown tag or a lost modified bit. Re-filling an existing tag has to reuse the entry and emit the old flags. A design that allocated a duplicate would stay silent and later hit twice. Permission faults must leave the flags unchanged, so a design that set them on a denied write would be caught by the next write-back. Flushes must last exactly ENTRIES cycles, spare the other identifiers and drop lookups issued while they run. An off-by-one scan would lose the last entry, and a lookup served during the scan would appear as an unexpected response.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int ASID_W = 8;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = PA_W - OFF_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic              valid;
        logic              refd;
        logic              dirty;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        perm_t             perm;
    } entry_t;

    function automatic logic access_ok(perm_t p, acc_e a);
        case (a)
            ACC_READ:  return p.r;
            ACC_WRITE: return p.w;
            ACC_FETCH: return p.x;
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  entry_t [N-1:0]    ents,
    input  logic [ASID_W-1:0] asid,
    input  logic [VPN_W-1:0]  vpn,
    output logic              any,
    output logic [IW-1:0]     idx
);
    logic [N-1:0] hv;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hv[g] = ents[g].valid && (ents[g].asid == asid) && (ents[g].vpn == vpn);
    end

    always_comb begin
        any = |hv;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hv[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  vld,
    input  logic          hit_any,
    input  logic [IW-1:0] hit_idx,
    output logic [IW-1:0] victim
);
    logic [15:0]   lfsr;
    logic          free_any;
    logic [IW-1:0] free_idx;

    always_ff @(posedge clk) begin
        if (rst) lfsr <= 16'hACE1;
        else     lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    always_comb begin
        free_any = ~&vld;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IW'(i);
        end
        if (hit_any)       victim = hit_idx;
        else if (free_any) victim = free_idx;
        else               victim = IW'(32'(lfsr) % N);
    end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_acc,
    input  logic              fill_valid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [2:0]        fill_perm,
    input  logic              flush_valid,
    input  logic              flush_all,
    input  logic [ASID_W-1:0] flush_asid,
    output logic              flush_busy,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              wb_valid,
    output logic [ASID_W-1:0] wb_asid,
    output logic [VPN_W-1:0]  wb_vpn,
    output logic              wb_ref,
    output logic              wb_dirty
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    entry_t [ENTRIES-1:0] ents;
    logic   [ENTRIES-1:0] vld;
    logic                 lk_any, fl_any;
    logic   [IW-1:0]      lk_idx, fl_idx, victim;
    logic   [IW-1:0]      scan;
    logic                 sc_all;
    logic   [ASID_W-1:0]  sc_asid;
    acc_e                 acc;
    entry_t               lk_ent, vic_ent, sc_ent;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
        assign vld[g] = ents[g].valid;
    end

    tlb_match #(.N(ENTRIES)) u_lk_match (
        .ents(ents), .asid(lk_asid), .vpn(lk_vaddr[VA_W-1:OFF_W]),
        .any(lk_any), .idx(lk_idx)
    );

    tlb_match #(.N(ENTRIES)) u_fl_match (
        .ents(ents), .asid(fill_asid), .vpn(fill_vpn),
        .any(fl_any), .idx(fl_idx)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .clk(clk), .rst(rst), .vld(vld),
        .hit_any(fl_any), .hit_idx(fl_idx), .victim(victim)
    );

    assign acc     = acc_e'(lk_acc);
    assign lk_ent  = ents[lk_idx];
    assign vic_ent = ents[victim];
    assign sc_ent  = ents[scan];

    always_ff @(posedge clk) begin
        if (rst) begin
            ents       <= '0;
            flush_busy <= 1'b0;
            scan       <= '0;
            sc_all     <= 1'b0;
            sc_asid    <= '0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_paddr  <= '0;
            wb_valid   <= 1'b0;
            wb_asid    <= '0;
            wb_vpn     <= '0;
            wb_ref     <= 1'b0;
            wb_dirty   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
            wb_valid  <= 1'b0;
            if (flush_busy) begin
                if (sc_ent.valid && (sc_all || sc_ent.asid == sc_asid)) begin
                    ents[scan].valid <= 1'b0;
                    wb_valid <= 1'b1;
                    wb_asid  <= sc_ent.asid;
                    wb_vpn   <= sc_ent.vpn;
                    wb_ref   <= sc_ent.refd;
                    wb_dirty <= sc_ent.dirty;
                end
                if (scan == IW'(ENTRIES - 1)) flush_busy <= 1'b0;
                else                          scan <= scan + 1'b1;
            end else if (flush_valid) begin
                flush_busy <= 1'b1;
                scan       <= '0;
                sc_all     <= flush_all;
                sc_asid    <= flush_asid;
            end else if (fill_valid) begin
                if (vic_ent.valid) begin
                    wb_valid <= 1'b1;
                    wb_asid  <= vic_ent.asid;
                    wb_vpn   <= vic_ent.vpn;
                    wb_ref   <= vic_ent.refd;
                    wb_dirty <= vic_ent.dirty;
                end
                ents[victim] <= '{valid: 1'b1, refd: 1'b0, dirty: 1'b0,
                                  asid: fill_asid, vpn: fill_vpn, ppn: fill_ppn,
                                  perm: perm_t'(fill_perm)};
            end else if (lk_valid) begin
                rsp_valid <= 1'b1;
                if (lk_any) begin
                    if (access_ok(lk_ent.perm, acc)) begin
                        rsp_hit   <= 1'b1;
                        rsp_paddr <= {lk_ent.ppn, lk_vaddr[OFF_W-1:0]};
                        ents[lk_idx].refd <= 1'b1;
                        if (acc == ACC_WRITE) ents[lk_idx].dirty <= 1'b1;
                    end else begin
                        rsp_fault <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk
    import tlb_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            fill_valid,
    input logic            flush_valid,
    input logic            flush_busy,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            wb_valid
);
    // R2 / R11: a response exists exactly when an unblocked lookup came one cycle earlier
    p_rsp_timing_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(lk_valid && !flush_busy && !flush_valid && !fill_valid));

    p_hit_fault_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(rsp_hit && rsp_fault));

    p_result_needs_rsp_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit || rsp_fault) |-> rsp_valid);

    p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    p_wb_source_r8: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(fill_valid || flush_busy));

    p_flush_start_r9: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && !flush_busy) |=> flush_busy);

    p_busy_blocks_r11: assert property (@(posedge clk) disable iff (rst)
        flush_busy |=> !rsp_valid);
endmodule

bind tlb_fa tlb_fa_chk u_chk (.*);

// File: tb/tlb_fa_test.sv
`timescale 1ns/1ps
module tlb_fa_test;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic [1:0]  lk_acc = '0;
    logic        fill_valid = 1'b0;
    logic [7:0]  fill_asid = '0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [2:0]  fill_perm = '0;
    logic        flush_valid = 1'b0;
    logic        flush_all = 1'b0;
    logic [7:0]  flush_asid = '0;
    logic        flush_busy, rsp_valid, rsp_hit, rsp_fault, wb_valid, wb_ref, wb_dirty;
    logic [31:0] rsp_paddr;
    logic [7:0]  wb_asid;
    logic [19:0] wb_vpn;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model of resident mappings (slot order is the bench's own)
    logic        m_v[N];
    logic [7:0]  m_asid[N];
    logic [19:0] m_vpn[N];
    logic [19:0] m_ppn[N];
    logic [2:0]  m_perm[N];
    logic        m_ref[N];
    logic        m_dirty[N];

    always #5 clk = ~clk;

    tlb_fa #(.ENTRIES(N)) uut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int find(input logic [7:0] a, input logic [19:0] v);
        for (int i = 0; i < N; i++) if (m_v[i] && m_asid[i] == a && m_vpn[i] == v) return i;
        return -1;
    endfunction

    function automatic int free_slot();
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        return -1;
    endfunction

    function automatic bit perm_ok(input logic [2:0] p, input logic [1:0] a);
        if (a == 2'd0) return p[0];
        if (a == 2'd1) return p[1];
        if (a == 2'd2) return p[2];
        return 1'b0;
    endfunction

    task automatic do_lookup(input logic [7:0] a, input logic [19:0] v,
                             input logic [1:0] acc, input string req);
        int k;
        logic [11:0] off;
        bit eh, ef;
        logic [31:0] epa;
        off = 12'($urandom);
        k = find(a, v);
        eh = 0; ef = 0; epa = '0;
        if (k >= 0) begin
            if (perm_ok(m_perm[k], acc)) begin
                eh = 1; epa = {m_ppn[k], off};
                m_ref[k] = 1'b1;
                if (acc == 2'd1) m_dirty[k] = 1'b1;
            end else ef = 1;
        end
        lk_valid = 1'b1; lk_vaddr = {v, off}; lk_asid = a; lk_acc = acc;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(rsp_valid == 1'b1, req, "rsp_valid", 64'(rsp_valid), 64'(1));
        chk(rsp_hit == eh, req, "rsp_hit", 64'(rsp_hit), 64'(eh));
        chk(rsp_fault == ef, req, "rsp_fault", 64'(rsp_fault), 64'(ef));
        if (eh) chk(rsp_paddr == epa, req, "rsp_paddr", 64'(rsp_paddr), 64'(epa));
    endtask

    task automatic do_fill(input logic [7:0] a, input logic [19:0] v, input logic [19:0] p,
                           input logic [2:0] pm, input bit with_lk, input string req);
        int k, f, s;
        k = find(a, v);
        f = free_slot();
        fill_valid = 1'b1; fill_asid = a; fill_vpn = v; fill_ppn = p; fill_perm = pm;
        if (with_lk) begin
            lk_valid = 1'b1; lk_asid = a; lk_vaddr = {v, 12'h0}; lk_acc = 2'd0;
        end
        @(negedge clk);
        fill_valid = 1'b0;
        lk_valid = 1'b0;
        if (with_lk) chk(rsp_valid == 1'b0, "R11", "lookup beside fill answered", 64'(rsp_valid), 64'(0));
        if (k >= 0) begin
            chk(wb_valid == 1'b1, req, "overwrite wb_valid", 64'(wb_valid), 64'(1));
            chk(wb_asid == a && wb_vpn == v, req, "overwrite wb tag", 64'({wb_asid, wb_vpn}), 64'({a, v}));
            chk(wb_ref == m_ref[k], req, "overwrite wb_ref", 64'(wb_ref), 64'(m_ref[k]));
            chk(wb_dirty == m_dirty[k], req, "overwrite wb_dirty", 64'(wb_dirty), 64'(m_dirty[k]));
            s = k;
        end else if (f >= 0) begin
            chk(wb_valid == 1'b0, "R7", "free-slot fill wb_valid", 64'(wb_valid), 64'(0));
            s = f;
        end else begin
            chk(wb_valid == 1'b1, "R8", "eviction wb_valid", 64'(wb_valid), 64'(1));
            s = find(wb_asid, wb_vpn);
            chk(s >= 0, "R8", "evicted tag resident", 64'({wb_asid, wb_vpn}), 64'(0));
            if (s >= 0) begin
                chk(wb_ref == m_ref[s], "R8", "evicted wb_ref", 64'(wb_ref), 64'(m_ref[s]));
                chk(wb_dirty == m_dirty[s], "R8", "evicted wb_dirty", 64'(wb_dirty), 64'(m_dirty[s]));
            end else s = 0;
        end
        m_v[s] = 1'b1; m_asid[s] = a; m_vpn[s] = v; m_ppn[s] = p; m_perm[s] = pm;
        m_ref[s] = 1'b0; m_dirty[s] = 1'b0;
    endtask

    task automatic do_flush(input bit all, input logic [7:0] a, input bit probe, input string req);
        int expn, got, busy_cnt, k;
        expn = 0; got = 0; busy_cnt = 0;
        for (int i = 0; i < N; i++) if (m_v[i] && (all || m_asid[i] == a)) expn++;
        flush_valid = 1'b1; flush_all = all; flush_asid = a;
        @(negedge clk);
        flush_valid = 1'b0;
        for (int it = 0; it < N + 4; it++) begin
            if (wb_valid) begin
                k = find(wb_asid, wb_vpn);
                chk(k >= 0 && (all || wb_asid == a), req, "flushed tag",
                    64'({wb_asid, wb_vpn}), 64'(a));
                if (k >= 0) begin
                    chk(wb_ref == m_ref[k], "R4", "flush wb_ref", 64'(wb_ref), 64'(m_ref[k]));
                    chk(wb_dirty == m_dirty[k], "R4", "flush wb_dirty", 64'(wb_dirty), 64'(m_dirty[k]));
                    m_v[k] = 1'b0;
                end
                got++;
            end
            if (!flush_busy) break;
            busy_cnt++;
            if (probe && it == 0) begin
                lk_valid = 1'b1; lk_vaddr = '0; lk_asid = a; lk_acc = 2'd0;
                @(negedge clk);
                lk_valid = 1'b0;
                chk(rsp_valid == 1'b0, "R11", "lookup during flush answered", 64'(rsp_valid), 64'(0));
            end else begin
                @(negedge clk);
            end
        end
        chk(busy_cnt == N, "R9", "busy cycles", 64'(busy_cnt), 64'(N));
        chk(got == expn, req, "flush record count", 64'(got), 64'(expn));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_asid[i] = '0; m_vpn[i] = '0; m_ppn[i] = '0;
            m_perm[i] = '0; m_ref[i] = 0; m_dirty[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(rsp_valid == 0 && wb_valid == 0 && flush_busy == 0, "R1", "idle outputs after reset",
            64'({rsp_valid, wb_valid, flush_busy}), 64'(0));
        do_lookup(8'd1, 20'h12345, 2'd0, "R1");

        // R7 / R2 / R5 / R3 / R4 / R6
        do_fill(8'd1, 20'h12345, 20'hABCDE, 3'b011, 0, "R7");
        do_lookup(8'd1, 20'h12345, 2'd0, "R2");
        do_lookup(8'd2, 20'h12345, 2'd0, "R5");
        do_lookup(8'd1, 20'h12345, 2'd2, "R3");
        do_lookup(8'd1, 20'h12345, 2'd3, "R3");
        do_lookup(8'd1, 20'h12345, 2'd1, "R4");
        do_fill(8'd1, 20'h12345, 20'h55555, 3'b001, 0, "R6");
        do_lookup(8'd1, 20'h12345, 2'd1, "R3");
        do_fill(8'd1, 20'h12345, 20'h66666, 3'b111, 1, "R6");

        // fill to full, then force a random eviction
        for (int i = 0; i < N - 1; i++) do_fill(8'd2, 20'h00100 + 20'(i), 20'(i * 7 + 3), 3'b111, 0, "R7");
        do_lookup(8'd2, 20'h00103, 2'd1, "R4");
        do_lookup(8'd2, 20'h00104, 2'd0, "R4");
        do_fill(8'd3, 20'h00777, 20'h0BEEF, 3'b101, 0, "R8");
        do_fill(8'd3, 20'h00778, 20'h0CAFE, 3'b101, 0, "R8");

        do_flush(0, 8'd2, 1, "R9");
        do_lookup(8'd3, 20'h00777, 2'd2, "R9");
        do_lookup(8'd2, 20'h00103, 2'd0, "R9");
        do_fill(8'd4, 20'h00900, 20'h00011, 3'b111, 0, "R7");
        do_flush(1, 8'd0, 0, "R10");
        do_lookup(8'd4, 20'h00900, 2'd0, "R10");
        do_lookup(8'd3, 20'h00777, 2'd2, "R10");

        // constrained random phase
        for (int n = 0; n < 1500; n++) begin
            int op;
            logic [7:0]  a;
            logic [19:0] v;
            op = int'($urandom % 64);
            a  = 8'($urandom % 3);
            v  = 20'h00400 + 20'($urandom % 24);
            if (op == 0)       do_flush(bit'($urandom % 2), a, 0, "R10");
            else if (op < 20)  do_fill(a, v, 20'($urandom), 3'($urandom), 0, "R8");
            else               do_lookup(a, v, 2'($urandom % 4), "R2");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule